// File: doc/BRIEF.md
# Keyed Flash Write Unlock Guard

This block stands between a host register port and a serial flash write path. Flash writes stay locked until the host writes a fixed six-byte key, one byte per write, to a dedicated unlock register. When the last key byte arrives in order, the `write_enable` output goes high and stays high. It drops again only when the host writes zero to the unlock register or when the block is reset. The block also holds two small control registers: one that puts the downstream serial flash interface into reset and takes it out again, and one that reports two conditions of the embedded processor, command mode and halted.

The key matcher is a state machine with seven states. ST_SEEK0 through ST_SEEK5 each wait for key byte 0 through 5, and ST_OPEN means the guard is unlocked. The transitions, all taken only on a write to the unlock address, are:
- **advance**: ST_SEEKn goes to ST_SEEKn+1 when the byte matches the expected key byte, and ST_SEEK5 goes to ST_OPEN.
- **restart**: a mismatching byte sends the matcher back to ST_SEEK0.
- **restart-primed**: a mismatching byte equal to 0xAA is treated as the first key byte, so the matcher goes to ST_SEEK1.
- **lock**: in ST_OPEN, a write of 0x00 goes back to ST_SEEK0.
- **hold**: in ST_OPEN, any other value leaves the state unchanged.

The default register addresses are 0x40 for unlock, 0x41 for interface reset and 0x42 for processor control. All three are parameters.

Top module: `hw_write_guard`

## Requirements
- R1: Writing 0xAA, 0x55, 0x50, 0x41, 0x52, 0x44 in that order to the unlock address drives `write_enable` high, and it stays high with no further writes.
- R2: `write_enable` is already high during the cycle in which the sixth key byte is presented with `wr_valid`, before the clock edge that accepts it.
- R3: A write of 0x00 to the unlock address drives `write_enable` low in that same cycle and keeps it low afterwards. Unlocking again needs the full key.
- R4: A byte that does not match the expected key byte restarts the match. If that byte is 0xAA, it counts as the first key byte.
- R5: Writes to other addresses, and cycles without `wr_valid`, leave the progress of the key match unchanged.
- R6: While the guard is unlocked, nonzero writes to the unlock address, including 0xAA, leave `write_enable` high.
- R7: Writing 0x20 to the interface-reset address sets `spi_if_reset` to 1, writing 0x00 sets it to 0, and any other value leaves it unchanged.
- R8: At the processor-control address, 0xC0 sets `proc_cmd_mode` and 0x40 sets `proc_halted`. Each stays set until reset, and other values change neither.
- R9: After reset, all four outputs are 0 and the matcher waits for the first key byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe for one cycle |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Byte being written |
| write_enable | output | 1 | Flash write permission |
| spi_if_reset | output | 1 | Holds the serial flash interface in reset |
| proc_cmd_mode | output | 1 | Embedded processor is in command mode |
| proc_halted | output | 1 | Embedded processor is halted |

## Verification
The assertions assume that `wr_addr` and `wr_data` carry known values whenever `wr_valid` is high. They also assume that each write lasts exactly one cycle, so the lock and hold properties can read each cycle as a separate write. The bench drives every write for a single clock cycle from the falling edge and lowers `wr_valid` after the rising edge. Between writes it leaves address and data at defined values, so no undefined byte ever reaches the matcher or the control registers.

// File: rtl/hwg_pkg.sv
package hwg_pkg;

    localparam int KEY_LEN = 6;
    localparam int BYTE_W  = 8;

    localparam logic [BYTE_W-1:0] KEY_FIRST = 8'hAA;
    localparam logic [BYTE_W-1:0] LOCK_VAL  = 8'h00;

    typedef enum logic [2:0] {
        ST_SEEK0 = 3'd0,
        ST_SEEK1 = 3'd1,
        ST_SEEK2 = 3'd2,
        ST_SEEK3 = 3'd3,
        ST_SEEK4 = 3'd4,
        ST_SEEK5 = 3'd5,
        ST_OPEN  = 3'd6
    } unlock_state_e;

    // Key byte expected at a given position of the sequence.
    function automatic logic [BYTE_W-1:0] key_at(input int unsigned idx);
        logic [BYTE_W-1:0] b;
        case (idx)
            0:       b = 8'hAA;
            1:       b = 8'h55;
            2:       b = 8'h50;
            3:       b = 8'h41;
            4:       b = 8'h52;
            default: b = 8'h44;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/key_matcher.sv
module key_matcher
    import hwg_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              en_o
);

    localparam int LAST_IDX = KEY_LEN - 1;

    unlock_state_e state_q, state_d;
    logic          hit;
    logic          lock_req;

    assign hit      = wr_valid && (wr_addr == UNLOCK_ADDR);
    assign lock_req = hit && (wr_data == LOCK_VAL);

    // Where a mismatching byte sends the matcher.
    function automatic unlock_state_e restart_to(input logic [BYTE_W-1:0] b);
        return (b == KEY_FIRST) ? ST_SEEK1 : ST_SEEK0;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK0;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (hit) begin
            unique case (state_q)
                ST_SEEK0: state_d = (wr_data == key_at(0)) ? ST_SEEK1 : restart_to(wr_data);
                ST_SEEK1: state_d = (wr_data == key_at(1)) ? ST_SEEK2 : restart_to(wr_data);
                ST_SEEK2: state_d = (wr_data == key_at(2)) ? ST_SEEK3 : restart_to(wr_data);
                ST_SEEK3: state_d = (wr_data == key_at(3)) ? ST_SEEK4 : restart_to(wr_data);
                ST_SEEK4: state_d = (wr_data == key_at(4)) ? ST_SEEK5 : restart_to(wr_data);
                ST_SEEK5: state_d = (wr_data == key_at(LAST_IDX)) ? ST_OPEN : restart_to(wr_data);
                ST_OPEN:  state_d = (wr_data == LOCK_VAL) ? ST_SEEK0 : ST_OPEN;
                default:  state_d = ST_SEEK0;
            endcase
        end
    end

    // Output logic: completion and lock both act within the write cycle
    always_comb begin
        unique case (state_q)
            ST_OPEN:  en_o = !lock_req;
            ST_SEEK5: en_o = hit && (wr_data == key_at(LAST_IDX));
            default:  en_o = 1'b0;
        endcase
    end

    a_r3_lock_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |-> !en_o);

    a_r3_lock_after: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |=> !en_o);

    a_r1_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && !lock_req) |=> (state_q == ST_OPEN));

    a_r5_progress_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(state_q));

    a_r2_enable_before_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_OPEN) |-> $past(en_o));

endmodule

// File: rtl/ctl_flag_reg.sv
module ctl_flag_reg
    import hwg_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h41,
    parameter logic [BYTE_W-1:0] SET_VAL   = 8'h20,
    parameter logic [BYTE_W-1:0] CLR_VAL   = 8'h00,
    parameter bit                CLEARABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              flag_o
);

    logic hit, set_req, clr_req;

    assign hit     = wr_valid && (wr_addr == REG_ADDR);
    assign set_req = hit && (wr_data == SET_VAL);

    generate
        if (CLEARABLE) begin : g_clear
            assign clr_req = hit && (wr_data == CLR_VAL);
        end else begin : g_sticky
            assign clr_req = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_o <= 1'b0;
        else if (set_req) flag_o <= 1'b1;
        else if (clr_req) flag_o <= 1'b0;
    end

    a_r7_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag_o);

    a_r8_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_req || clr_req) |=> $stable(flag_o));

endmodule

// File: rtl/hw_write_guard.sv
module hw_write_guard
    import hwg_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] IFRST_ADDR  = 8'h41,
    parameter logic [ADDR_W-1:0] PROC_ADDR   = 8'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              write_enable,
    output logic              spi_if_reset,
    output logic              proc_cmd_mode,
    output logic              proc_halted
);

    key_matcher #(
        .ADDR_W(ADDR_W), .UNLOCK_ADDR(UNLOCK_ADDR)
    ) u_match (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .en_o(write_enable)
    );

    ctl_flag_reg #(
        .ADDR_W(ADDR_W), .REG_ADDR(IFRST_ADDR),
        .SET_VAL(8'h20), .CLR_VAL(8'h00), .CLEARABLE(1'b1)
    ) u_ifrst (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .flag_o(spi_if_reset)
    );

    ctl_flag_reg #(
        .ADDR_W(ADDR_W), .REG_ADDR(PROC_ADDR),
        .SET_VAL(8'hC0), .CLR_VAL(8'h00), .CLEARABLE(1'b0)
    ) u_cmdmode (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .flag_o(proc_cmd_mode)
    );

    ctl_flag_reg #(
        .ADDR_W(ADDR_W), .REG_ADDR(PROC_ADDR),
        .SET_VAL(8'h40), .CLR_VAL(8'h00), .CLEARABLE(1'b0)
    ) u_halt (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .flag_o(proc_halted)
    );

    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !(spi_if_reset || proc_cmd_mode || proc_halted));

endmodule

// File: tb/test_hw_write_guard.sv
module test_hw_write_guard;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_UNL = 8'h40;
    localparam logic [7:0] A_RST = 8'h41;
    localparam logic [7:0] A_PRC = 8'h42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic write_enable, spi_if_reset, proc_cmd_mode, proc_halted;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic comb_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    hw_write_guard i_hw_write_guard (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .write_enable(write_enable), .spi_if_reset(spi_if_reset),
        .proc_cmd_mode(proc_cmd_mode), .proc_halted(proc_halted)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One-cycle write; comb_en samples write_enable while the write is presented.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1 comb_en = write_enable;
        @(posedge clk);
        #1 wr_valid = 1'b0;
    endtask

    task automatic send_key();
        wr(A_UNL, 8'hAA); wr(A_UNL, 8'h55); wr(A_UNL, 8'h50);
        wr(A_UNL, 8'h41); wr(A_UNL, 8'h52); wr(A_UNL, 8'h44);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R9 write_enable", write_enable, 1'b0);
        check("R9 spi_if_reset", spi_if_reset, 1'b0);
        check("R9 proc_cmd_mode", proc_cmd_mode, 1'b0);
        check("R9 proc_halted", proc_halted, 1'b0);
    endtask

    task automatic t_unlock();
        wr(A_UNL, 8'hAA); wr(A_UNL, 8'h55); wr(A_UNL, 8'h50);
        wr(A_UNL, 8'h41); wr(A_UNL, 8'h52);
        check("R1 locked before last byte", comb_en, 1'b0);
        wr(A_UNL, 8'h44);
        check("R2 enable in sixth byte cycle", comb_en, 1'b1);
        check("R1 enable after key", write_enable, 1'b1);
        idle(5);
        check("R1 enable stays", write_enable, 1'b1);
    endtask

    task automatic t_lock();
        wr(A_UNL, 8'h00);
        check("R3 lock same cycle", comb_en, 1'b0);
        check("R3 lock after", write_enable, 1'b0);
        wr(A_UNL, 8'h55); wr(A_UNL, 8'h50); wr(A_UNL, 8'h41);
        wr(A_UNL, 8'h52); wr(A_UNL, 8'h44);
        check("R3 partial key after lock", write_enable, 1'b0);
    endtask

    task automatic t_restart();
        wr(A_UNL, 8'hAA); wr(A_UNL, 8'h55); wr(A_UNL, 8'h50); wr(A_UNL, 8'h13);
        wr(A_UNL, 8'h41); wr(A_UNL, 8'h52); wr(A_UNL, 8'h44);
        check("R4 mismatch restarts", write_enable, 1'b0);
        wr(A_UNL, 8'hAA); wr(A_UNL, 8'h55); wr(A_UNL, 8'hAA);
        wr(A_UNL, 8'h55); wr(A_UNL, 8'h50); wr(A_UNL, 8'h41);
        wr(A_UNL, 8'h52); wr(A_UNL, 8'h44);
        check("R4 0xAA mismatch counts as first", write_enable, 1'b1);
        wr(A_UNL, 8'h00);
    endtask

    task automatic t_other_addr();
        wr(A_UNL, 8'hAA); wr(A_UNL, 8'h55);
        wr(8'h7F, 8'h13); wr(A_PRC, 8'h00); wr(A_RST, 8'hAA);
        wr(A_UNL, 8'h50);
        @(negedge clk); wr_addr = A_UNL; wr_data = 8'h00; idle(2);
        wr(A_UNL, 8'h41); wr(8'h00, 8'h00); wr(A_UNL, 8'h52); wr(A_UNL, 8'h44);
        check("R5 other addresses keep progress", write_enable, 1'b1);
        wr(A_UNL, 8'h00);
        check("R5 relock", write_enable, 1'b0);
    endtask

    task automatic t_open_ignore();
        send_key();
        wr(A_UNL, 8'h13); wr(A_UNL, 8'hAA); wr(A_UNL, 8'h44);
        check("R6 nonzero writes ignored while open", write_enable, 1'b1);
        wr(A_UNL, 8'h00);
    endtask

    task automatic t_iface();
        wr(A_RST, 8'h20);
        check("R7 hold in reset", spi_if_reset, 1'b1);
        wr(A_RST, 8'h55);
        check("R7 other value keeps 1", spi_if_reset, 1'b1);
        wr(A_RST, 8'h00);
        check("R7 release", spi_if_reset, 1'b0);
        wr(A_RST, 8'h77);
        check("R7 other value keeps 0", spi_if_reset, 1'b0);
    endtask

    task automatic t_proc();
        wr(A_PRC, 8'h12);
        check("R8 other value no cmd", proc_cmd_mode, 1'b0);
        check("R8 other value no halt", proc_halted, 1'b0);
        wr(A_PRC, 8'hC0);
        check("R8 cmd mode set", proc_cmd_mode, 1'b1);
        check("R8 halt not set by C0", proc_halted, 1'b0);
        wr(A_PRC, 8'h40);
        check("R8 halted set", proc_halted, 1'b1);
        wr(A_PRC, 8'h00);
        check("R8 cmd mode sticky", proc_cmd_mode, 1'b1);
        check("R8 halted sticky", proc_halted, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        t_reset();
        t_unlock();
        t_lock();
        t_restart();
        t_other_addr();
        t_open_ignore();
        t_iface();
        t_proc();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule